// File: doc/BRIEF.md
# Register Alias Table Renamer

This block tracks, for every architectural register, which in-flight reorder-buffer entry will deliver that register's newest value. It sits at the rename step of an out-of-order core. Each cycle it accepts at most one instruction. For that instruction it looks up two source registers and can record one destination. For each source it reports one of two answers. Either the operand is already in the committed register file, or it is still pending on a reorder-buffer entry, and then the block gives that entry's tag. Because a destination is mapped to a fresh entry tag, later readers follow the newest writer. This removes write-after-read and write-after-write hazards and leaves only true data dependencies.

Two other events change the table. When an entry retires, its mapping is released, but only if the table still points at that entry and no younger writer has replaced it. When a branch mispredict flushes the pipeline, every register goes back to the committed register file in one cycle. Value storage, execution and prediction are outside this block.

The lookup results are registered. They appear one cycle after the request and reflect the table as it stood at the start of the request cycle.

Top module: `rat_renamer`

## Requirements
- R1: After reset, `look_valid`, both busy flags and both tags are 0, and every architectural register maps to the committed register file (busy = 0).
- R2: If `ren_valid` is 1 and `flush` is 0 in cycle N, then in cycle N+1 `look_valid` = 1. Each source then reports busy = 1 and the tag of the newest recorded writer of its register, or busy = 0 and tag = 0 if no writer is recorded. In any cycle where `look_valid` = 0, both busy flags and both tags are 0.
- R3: `ren_valid` = 1 and `ren_dst_we` = 1 (without flush) record `ren_tag` as the newest writer of `ren_dst`. A later write to the same register replaces the earlier one.
- R4: A lookup uses the table as it was at the start of the request cycle. A source equal to the same-cycle destination, or to a same-cycle committing register, gets the mapping from before that cycle's update.
- R5: With `cmt_valid` = 1, a register `cmt_reg` whose recorded tag equals `cmt_tag` reverts to the committed register file.
- R6: A commit whose tag differs from the recorded tag, or one given while `cmt_valid` = 0, leaves the mapping unchanged.
- R7: If a commit and a destination write hit the same register in one cycle, the write wins and the register stays busy with the new tag.
- R8: `flush` = 1 reverts every register to the committed register file by the next cycle. It discards any rename presented in the same cycle, and `look_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src0 | input | 3 | First source architectural register |
| ren_src1 | input | 3 | Second source architectural register |
| ren_dst_we | input | 1 | The instruction writes a destination |
| ren_dst | input | 3 | Destination architectural register |
| ren_tag | input | 4 | Reorder-buffer entry allocated to the destination |
| cmt_valid | input | 1 | An entry is retiring |
| cmt_reg | input | 3 | Architectural register written by the retiring entry |
| cmt_tag | input | 4 | Tag of the retiring entry |
| flush | input | 1 | Mispredict flush, revert all mappings |
| look_valid | output | 1 | Lookup results below are valid |
| src0_busy | output | 1 | First source pending on an in-flight entry |
| src0_tag | output | 4 | Producing entry of first source (0 when not busy) |
| src1_busy | output | 1 | Second source pending on an in-flight entry |
| src1_tag | output | 4 | Producing entry of second source (0 when not busy) |

## Verification
Random streams with all eight registers in use keep producing chains of overwrites, which show whether a lookup follows the newest writer or an older one. Commit tags are drawn half the time from the tag currently recorded and half at random, so matching releases are separated from stale ones that must be ignored. Directed cases put a source on the same register as the same-cycle destination or commit, and they collide a commit with a write. Together these show whether the lookup reads pre-update state and whether the write takes priority. Flushes, including one carrying a rename, show that the reset is complete and that the rename is dropped.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int DEF_NREG = 8;
  localparam int DEF_TAGW = 4;
  localparam int DEF_NSRC = 2;
endpackage

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int NREG = rat_pkg::DEF_NREG,
  parameter int TAGW = rat_pkg::DEF_TAGW,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [IDXW-1:0]            wr_idx,
  input  logic [TAGW-1:0]            wr_tag,
  input  logic                       cm_en,
  input  logic [IDXW-1:0]            cm_idx,
  input  logic [TAGW-1:0]            cm_tag,
  output logic [NREG-1:0]            busy_q,
  output logic [NREG-1:0][TAGW-1:0]  tag_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic hit_wr, hit_cm;
    assign hit_wr = wr_en && (wr_idx == IDXW'(g));
    assign hit_cm = cm_en && (cm_idx == IDXW'(g)) && busy_q[g] && (tag_q[g] == cm_tag);
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        busy_q[g] <= 1'b0;
        tag_q[g]  <= '0;
      end else if (hit_wr) begin
        busy_q[g] <= 1'b1;
        tag_q[g]  <= wr_tag;
      end else if (hit_cm) begin
        busy_q[g] <= 1'b0;
        tag_q[g]  <= '0;
      end
    end
  end

  p_flush_all_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> ($countones(busy_q) == 0));
  p_write_rec_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> (busy_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
  p_commit_rel_r5: assert property (@(posedge clk) disable iff (rst)
    (cm_en && !flush && busy_q[cm_idx] && tag_q[cm_idx] == cm_tag && !(wr_en && wr_idx == cm_idx))
    |=> !busy_q[$past(cm_idx)]);
  p_commit_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (cm_en && !flush && tag_q[cm_idx] != cm_tag && !(wr_en && wr_idx == cm_idx))
    |=> (busy_q[$past(cm_idx)] == $past(busy_q[cm_idx]) && tag_q[$past(cm_idx)] == $past(tag_q[cm_idx])));
endmodule

// File: rtl/rat_src_read.sv
module rat_src_read #(
  parameter int NREG = rat_pkg::DEF_NREG,
  parameter int TAGW = rat_pkg::DEF_TAGW,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req,
  input  logic [IDXW-1:0]            idx,
  input  logic [NREG-1:0]            busy_v,
  input  logic [NREG-1:0][TAGW-1:0]  tag_v,
  output logic                       busy_o,
  output logic [TAGW-1:0]            tag_o
);
  always_ff @(posedge clk) begin
    if (rst || !req) begin
      busy_o <= 1'b0;
      tag_o  <= '0;
    end else begin
      busy_o <= busy_v[idx];
      tag_o  <= busy_v[idx] ? tag_v[idx] : '0;
    end
  end

  p_tag_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (tag_o == '0));
  p_pre_update_r4: assert property (@(posedge clk) disable iff (rst)
    req |=> (busy_o == $past(busy_v[idx])));
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer #(
  parameter int NREG = rat_pkg::DEF_NREG,
  parameter int TAGW = rat_pkg::DEF_TAGW,
  localparam int IDXW = $clog2(NREG),
  localparam int NSRC = rat_pkg::DEF_NSRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ren_valid,
  input  logic [IDXW-1:0] ren_src0,
  input  logic [IDXW-1:0] ren_src1,
  input  logic            ren_dst_we,
  input  logic [IDXW-1:0] ren_dst,
  input  logic [TAGW-1:0] ren_tag,
  input  logic            cmt_valid,
  input  logic [IDXW-1:0] cmt_reg,
  input  logic [TAGW-1:0] cmt_tag,
  input  logic            flush,
  output logic            look_valid,
  output logic            src0_busy,
  output logic [TAGW-1:0] src0_tag,
  output logic            src1_busy,
  output logic [TAGW-1:0] src1_tag
);
  logic [NREG-1:0]           busy_q;
  logic [NREG-1:0][TAGW-1:0] tag_q;
  logic                      req;
  logic [NSRC-1:0][IDXW-1:0] s_idx;
  logic [NSRC-1:0]           s_busy;
  logic [NSRC-1:0][TAGW-1:0] s_tag;

  assign req      = ren_valid && !flush;
  assign s_idx[0] = ren_src0;
  assign s_idx[1] = ren_src1;

  rat_map_table #(.NREG(NREG), .TAGW(TAGW)) u_table (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(ren_valid && ren_dst_we), .wr_idx(ren_dst), .wr_tag(ren_tag),
    .cm_en(cmt_valid), .cm_idx(cmt_reg), .cm_tag(cmt_tag),
    .busy_q(busy_q), .tag_q(tag_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rat_src_read #(.NREG(NREG), .TAGW(TAGW)) u_rd (
      .clk(clk), .rst(rst), .req(req), .idx(s_idx[s]),
      .busy_v(busy_q), .tag_v(tag_q),
      .busy_o(s_busy[s]), .tag_o(s_tag[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) look_valid <= 1'b0;
    else     look_valid <= req;
  end

  assign src0_busy = s_busy[0];
  assign src0_tag  = s_tag[0];
  assign src1_busy = s_busy[1];
  assign src1_tag  = s_tag[1];

  p_flush_drop_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !look_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !look_valid |-> (!src0_busy && !src1_busy));
endmodule

// File: tb/rat_renamer_test.sv
`timescale 1ns/1ps
module rat_renamer_test;
  logic clk = 1'b0, rst = 1'b1;
  logic ren_valid = 0, ren_dst_we = 0, cmt_valid = 0, flush = 0;
  logic [2:0] ren_src0 = 0, ren_src1 = 0, ren_dst = 0, cmt_reg = 0;
  logic [3:0] ren_tag = 0, cmt_tag = 0;
  logic look_valid, src0_busy, src1_busy;
  logic [3:0] src0_tag, src1_tag;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  bit mb[8];
  logic [3:0] mt[8];
  bit e_ok;
  bit e_b0, e_b1;
  logic [3:0] e_t0, e_t1;
  string e_lbl;
  bit e_pend = 0;

  always #2.5 clk = ~clk;

  rat_renamer uut (.*);

  task automatic chk(string lbl, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 8; i++) begin mb[i] = 0; mt[i] = 0; end
  endfunction

  task automatic check_prev();
    if (!e_pend) return;
    chk(e_lbl, "look_valid", look_valid, e_ok);
    chk(e_lbl, "src0_busy", src0_busy, e_b0);
    chk(e_lbl, "src0_tag", src0_tag, e_t0);
    chk(e_lbl, "src1_busy", src1_busy, e_b1);
    chk(e_lbl, "src1_tag", src1_tag, e_t1);
  endtask

  // one cycle: called at negedge; checks the last request, drives new inputs, updates the model
  task automatic step(bit v, bit [2:0] s0, bit [2:0] s1, bit we, bit [2:0] d, bit [3:0] t,
                      bit cv, bit [2:0] cr, bit [3:0] ct, bit fl, string lbl);
    check_prev();
    ren_valid = v; ren_src0 = s0; ren_src1 = s1; ren_dst_we = we; ren_dst = d; ren_tag = t;
    cmt_valid = cv; cmt_reg = cr; cmt_tag = ct; flush = fl;
    e_ok = v && !fl;
    e_b0 = e_ok && mb[s0]; e_t0 = e_b0 ? mt[s0] : 4'd0;
    e_b1 = e_ok && mb[s1]; e_t1 = e_b1 ? mt[s1] : 4'd0;
    if (lbl != "") e_lbl = lbl;
    else if (fl) e_lbl = "R8";
    else if (v && we && (s0 == d || s1 == d)) e_lbl = "R4";
    else if (e_b0 || e_b1) e_lbl = "R3";
    else e_lbl = "R2";
    e_pend = 1;
    if (fl) model_clear();
    else begin
      if (cv && mb[cr] && mt[cr] == ct && !(v && we && d == cr)) begin mb[cr] = 0; mt[cr] = 0; end
      if (v && we) begin mb[d] = 1; mt[d] = t; end
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "look_valid", look_valid, 0);
    chk("R1", "src0_busy", src0_busy, 0);
    chk("R1", "src1_tag", src1_tag, 0);
    for (int r = 0; r < 8; r += 2) step(1, 3'(r), 3'(r+1), 0, 0, 0, 0, 0, 0, 0, "R1");
    // R3 record and WAW overwrite
    step(1, 0, 0, 1, 3'd2, 4'd5, 0, 0, 0, 0, "R3");
    step(1, 2, 2, 1, 3'd2, 4'd9, 0, 0, 0, 0, "R3");
    step(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R4 source equals same-cycle destination
    step(1, 3, 3, 1, 3'd3, 4'd7, 0, 0, 0, 0, "R4");
    step(1, 3, 2, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R4 source on same-cycle commit, R6 stale commit
    step(1, 2, 2, 0, 0, 0, 1, 3'd2, 4'd5, 0, "R6");
    step(1, 2, 2, 0, 0, 0, 0, 3'd2, 4'd9, 0, "R6");
    step(1, 2, 3, 0, 0, 0, 1, 3'd2, 4'd9, 0, "R4");
    // R5 matching commit released
    step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R7 commit and write collide
    step(1, 0, 0, 1, 3'd3, 4'd12, 1, 3'd3, 4'd7, 0, "R7");
    step(1, 3, 3, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R8 flush carrying a rename
    step(1, 3, 3, 1, 3'd4, 4'd1, 0, 0, 0, 1, "R8");
    step(1, 3, 4, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 3, 4, 0, 0, 0, 0, 0, 0, 0, "R2");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit [2:0] cr;
      bit [3:0] ct;
      cr = 3'($urandom_range(7));
      ct = ($urandom_range(1) == 1) ? mt[cr] : 4'($urandom_range(15));
      step($urandom_range(3) != 0, 3'($urandom_range(7)), 3'($urandom_range(7)),
           $urandom_range(2) != 0, 3'($urandom_range(7)), 4'($urandom_range(15)),
           $urandom_range(2) == 0, cr, ct, $urandom_range(31) == 0, "");
    end
    check_prev();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule